// File: doc/BRIEF.md
# Multi-Channel Pulse-Width DAC Bank

This block drives a bank of pulse-width-modulated outputs. Each output, once filtered off-chip, serves as a slow analog control voltage in a display-monitor controller. Every channel owns an 8-bit duty register on a plain register bus, with one byte per channel at consecutive addresses. Writes go in through a strobe. Reads return data combinationally from the addressed byte.

A shared prescaler turns the system clock into frame steps. A frame counter runs through either a 256-step frame or a shorter 253-step frame. Each channel compares the step count with its own duty code and holds a registered output. A rate-select input picks the fast or the slow step rate. The slow rate is half the fast one, which gives the two frame frequencies. A divide-mode input picks the frame length. The 253-step frame lets the top three codes produce a steady high. The 256-step frame always leaves one low step at full code.

New duty codes and new mode settings are taken up only on a frame boundary, so a write can never cut a pulse short or stretch it.

Top module: `pwm_dac_bank`

## Requirements
- R1: Channel n (0 to NUM_CH-1, default 14 channels) has an 8-bit duty register at bus address n. A write with `wr_en` high stores `wr_data` there on the clock edge. Writes to addresses at or above NUM_CH are ignored.
- R2: `rd_data` returns, in the same cycle, the register addressed by `bus_addr`. Addresses at or above NUM_CH read as 00h.
- R3: After reset every duty register, and every channel's active duty, holds 80h. The bank starts in 256-step mode at the fast rate.
- R4: With `rate_slow`=0 the frame advances one step per FAST_DIV clocks (default 1). With `rate_slow`=1 it advances one step per SLOW_DIV clocks (default 2). A frame therefore lasts steps x divisor clocks.
- R5: With `div253`=0 the frame has 256 steps and a channel is high for exactly `code` steps per frame. Code FFh gives 255 high steps and one low step in every frame.
- R6: With `div253`=1 the frame has 253 steps. Codes 01h to FCh give `code` high steps per frame, and codes FDh, FEh and FFh give a constant high output.
- R7: Code 00h gives a constant low output in both modes.
- R8: A channel's output is high while the step count is below its active duty. Each channel's active duty, and the bank's active rate and mode, are reloaded only at the end of a frame. The output of a channel rises at the first step of each frame whenever its active code is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Register address, one byte per channel |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| rate_slow | input | 1 | 1 selects the slow step rate |
| div253 | input | 1 | 1 selects the 253-step frame |
| pwm_out | output | NUM_CH (14) | Pulse-width outputs, bit n for channel n |

## Verification
The high time of each output is counted over one full frame for a set of codes that separate the rendering rules: 00h, 01h, a mid-scale code, 7Fh, and the edge codes FDh, FEh and FFh. This set is run in all four combinations of frame length and rate. Only FDh to FFh separate the two frame modes, only FFh exposes the compulsory low step, and the rate combinations show that the divisor scales the high time. One channel set to code 01h marks each frame start. Against that marker, a write in mid-frame is shown to take effect exactly at the next frame and not before. The marker period also confirms the frame length.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int CODE_W      = 8;
  localparam int STEPS_FULL  = 256;
  localparam int STEPS_SHORT = 253;
  localparam logic [CODE_W-1:0] CODE_RESET = 8'h80;

  function automatic logic [CODE_W-1:0] frame_last(input logic short_mode);
    frame_last = short_mode ? CODE_W'(STEPS_SHORT - 1) : CODE_W'(STEPS_FULL - 1);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic step_tick
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] div_m1;

  always_comb begin
    div_m1    = slow_sel ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
    step_tick = (cnt_q >= div_m1);
    cnt_d     = step_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr
  import pwm_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_tick,
  input  logic              cfg_slow,
  input  logic              cfg_short,
  output logic [CODE_W-1:0] step,
  output logic              frame_wrap,
  output logic              act_slow,
  output logic              act_short
);
  logic [CODE_W-1:0] step_d;
  logic              slow_d, short_d;
  logic              step_en;

  always_comb begin
    step_en    = step_tick;
    frame_wrap = step_tick && (step == frame_last(act_short));
    step_d     = frame_wrap ? '0 : step + 1'b1;
    slow_d     = frame_wrap ? cfg_slow  : act_slow;
    short_d    = frame_wrap ? cfg_short : act_short;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= '0;
      act_slow  <= 1'b0;
      act_short <= 1'b0;
    end else begin
      if (step_en) step <= step_d;
      act_slow  <= slow_d;
      act_short <= short_d;
    end
  end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int AW     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            bus_addr,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [CODE_W-1:0]        rd_data,
  output logic [NUM_CH*CODE_W-1:0] regs_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    logic              hit;
    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
      hit    = wr_en && (bus_addr == AW'(c));
      code_d = hit ? wr_data : code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= CODE_RESET;
      else        code_q <= code_d;
    end

    assign regs_flat[c*CODE_W +: CODE_W] = code_q;
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == AW'(c)) rd_data = regs_flat[c*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_wrap,
  input  logic [CODE_W-1:0] reg_code,
  input  logic [CODE_W-1:0] step,
  output logic [CODE_W-1:0] act_code,
  output logic              pwm
);
  logic [CODE_W-1:0] code_d;
  logic              pwm_d;

  always_comb begin
    code_d = frame_wrap ? reg_code : act_code;
    pwm_d  = (step < act_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= CODE_RESET;
      pwm      <= 1'b0;
    end else begin
      act_code <= code_d;
      pwm      <= pwm_d;
    end
  end
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH   = 14,
  parameter int AW       = 4,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              rate_slow,
  input  logic              div253,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                     step_tick;
  logic                     frame_wrap;
  logic [CODE_W-1:0]        step;
  logic                     act_slow;
  logic                     act_short;
  logic [NUM_CH*CODE_W-1:0] regs_flat;
  logic [NUM_CH*CODE_W-1:0] act_flat;

  pwm_regfile #(.NUM_CH(NUM_CH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
    .wr_data(wr_data), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  pwm_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_sel(act_slow), .step_tick(step_tick)
  );

  pwm_frame_ctr u_frame (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
    .cfg_slow(rate_slow), .cfg_short(div253),
    .step(step), .frame_wrap(frame_wrap),
    .act_slow(act_slow), .act_short(act_short)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .frame_wrap(frame_wrap),
      .reg_code(regs_flat[c*CODE_W +: CODE_W]), .step(step),
      .act_code(act_flat[c*CODE_W +: CODE_W]), .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int NUM_CH = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_tick,
  input logic                frame_wrap,
  input logic [7:0]          step,
  input logic                act_short,
  input logic [NUM_CH*8-1:0] act_flat,
  input logic [NUM_CH-1:0]   pwm_out
);
  assert_step_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_short |-> (step <= 8'd252));

  assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step) |-> $past(step_tick));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_load_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_flat[c*8 +: 8]) |-> $past(frame_wrap));

    assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act_flat[c*8 +: 8] == 8'h00) |-> !pwm_out[c]);

    assert_top_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act_short && (act_flat[c*8 +: 8] >= 8'd253)) |-> pwm_out[c]);

    assert_full_low_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!act_short && (act_flat[c*8 +: 8] == 8'hFF) && (step == 8'hFF)) |-> !pwm_out[c]);
  end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .frame_wrap(frame_wrap),
  .step(step), .act_short(act_short), .act_flat(act_flat), .pwm_out(pwm_out)
);

// File: tb/pwm_dac_bank_tb.sv
module pwm_dac_bank_tb;
  localparam int NUM_CH = 14;
  localparam int AW     = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [AW-1:0]     bus_addr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic              rate_slow;
  logic              div253;
  logic [NUM_CH-1:0] pwm_out;

  pwm_dac_bank #(.NUM_CH(NUM_CH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
    .wr_data(wr_data), .rd_data(rd_data), .rate_slow(rate_slow),
    .div253(div253), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    int    ch;
    int    exp_high;
    int    len;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  task automatic report(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures high clocks over one frame length per expected item
  initial begin
    forever begin
      sb_item_t it;
      int hi;
      wait (sb_q.size() > 0);
      it = sb_q[0];
      hi = 0;
      for (int i = 0; i < it.len; i++) begin
        @(negedge clk);
        if (pwm_out[it.ch]) hi++;
      end
      report(hi == it.exp_high, it.tag, hi, it.exp_high);
      void'(sb_q.pop_front());
    end
  end

  function automatic int exp_high(input int code, input bit shortm, input bit slow);
    int dv = slow ? 2 : 1;
    if (code == 0) return 0;
    if (shortm && code >= 253) return 253 * dv;
    return code * dv;
  endfunction

  task automatic push(input int ch, input int code, input string tag);
    sb_item_t it;
    it.ch       = ch;
    it.exp_high = exp_high(code, div253, rate_slow);
    it.len      = (div253 ? 253 : 256) * (rate_slow ? 2 : 1);
    it.tag      = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    wr_en    = 1'b1;
    bus_addr = AW'(a);
    wr_data  = 8'(d);
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic bus_check(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    report(rd_data == 8'(exp), tag, rd_data, exp);
  endtask

  task automatic settle();
    repeat (3 * 512) @(negedge clk);
  endtask

  int codes [7] = '{8'h00, 8'h01, 8'h40, 8'h7F, 8'hFD, 8'hFE, 8'hFF};

  task automatic run_codes(input string tag);
    for (int i = 0; i < 7; i++) push(i, codes[i], tag);
    drain();
  endtask

  task automatic wait_marker_rise(output int gap, output bit ch0_early);
    bit prev;
    gap = 0;
    ch0_early = 0;
    prev = pwm_out[13];
    forever begin
      @(negedge clk);
      gap++;
      if (!prev && pwm_out[13]) break;
      if (pwm_out[0]) ch0_early = 1;
      prev = pwm_out[13];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int  gap;
    bit  early;
    rst_n     = 1'b0;
    wr_en     = 1'b0;
    bus_addr  = '0;
    wr_data   = '0;
    rate_slow = 1'b0;
    div253    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset contents, R2 read path
    for (int c = 0; c < NUM_CH; c++) bus_check(c, 8'h80, "R3 reset code / R2 read");
    bus_check(14, 0, "R2 unmapped address reads 00h");
    push(0, 8'h80, "R3 mid-scale output after reset");
    push(13, 8'h80, "R3 mid-scale output after reset");
    drain();

    // R1 write ignored above the channel range
    bus_write(15, 8'h5A);
    bus_check(15, 0, "R1 unmapped write ignored");
    for (int c = 0; c < NUM_CH; c++) bus_check(c, 8'h80, "R1 unmapped write leaves channels");

    // R1/R2 program test codes
    for (int i = 0; i < 7; i++) bus_write(i, codes[i]);
    bus_write(13, 8'h01);
    for (int i = 0; i < 7; i++) bus_check(i, codes[i], "R1 write readback");
    settle();

    run_codes("R5 R7 256-step fast");
    wait_marker_rise(gap, early);
    wait_marker_rise(gap, early);
    report(gap == 256, "R4 fast 256-step frame period", gap, 256);

    div253 = 1'b1;
    settle();
    run_codes("R6 R7 253-step fast");
    wait_marker_rise(gap, early);
    wait_marker_rise(gap, early);
    report(gap == 253, "R6 253-step frame period", gap, 253);

    rate_slow = 1'b1;
    div253    = 1'b0;
    settle();
    run_codes("R4 R5 256-step slow");
    wait_marker_rise(gap, early);
    wait_marker_rise(gap, early);
    report(gap == 512, "R4 slow 256-step frame period", gap, 512);

    div253 = 1'b1;
    settle();
    run_codes("R4 R6 253-step slow");

    // R8 mid-frame write takes effect only at the next frame start
    rate_slow = 1'b0;
    div253    = 1'b0;
    settle();
    wait_marker_rise(gap, early);
    repeat (60) @(negedge clk);
    bus_write(0, 8'hFF);
    wait_marker_rise(gap, early);
    report(!early, "R8 no early pulse after mid-frame write", early, 0);
    report(pwm_out[0] == 1'b1, "R8 new code starts with frame", pwm_out[0], 1);
    push(0, 8'hFF, "R8 new code full frame");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule